// File: doc/BRIEF.md
# Pair-Timed Binary Plastic Synapse

This block is a single on/off synapse that learns from the relative timing of spikes on two lines: a source (presynaptic) spike line and a target (postsynaptic) spike line. All state advances only on a one-cycle step strobe, so one strobe is one network time step. Each line keeps a short memory of its most recent spike. The memory is a down-counter that is loaded with a programmable window length when that line spikes. The memory counts as active while the counter is non-zero.

A target spike that arrives while the source memory is active is a potentiation event, and it switches a latched transmission gate on. A source spike that arrives while the target memory is active is a depression event, and it switches the gate off. Either event erases both memories. While the gate is on, each source spike is delivered on the forwarded-spike output through a relay register, two steps after it arrived. While the gate is off, source spikes are dropped. The gate and the two event flags are brought out, so that the learned state can be seen from outside the block.

Top module: `stdp_synapse`

## Requirements
- R1: A source spike loads the source memory with `win_len`. A target spike in any of the next `win_len` steps (step 1 through `win_len` after the source spike) is a potentiation. A target spike `win_len`+1 steps later is not. With `win_len` = 0 no event can follow.
- R2: `ltp_evt` is 1 for the step interval after a strobe in which a target spike met an active source memory, and 0 after other strobes.
- R3: `ltd_evt` is 1 for the step interval after a strobe in which a source spike met an active target memory, and 0 after other strobes.
- R4: A step with either event clears both memories, including any memory that a spike in that same step would otherwise have loaded.
- R5: `gate_on` becomes 1 at the strobe that detects a potentiation without a depression, and it stays 1 until a depression.
- R6: `gate_on` becomes 0 at the strobe that detects a depression, and it stays 0 until the next potentiation.
- R7: When both events are detected in the same step, depression wins and `gate_on` ends at 0.
- R8: A source spike in step n, with `gate_on` = 1 during step n, makes `fwd_spk` = 1 for exactly the interval after strobe n+1.
- R9: A source spike arriving while `gate_on` = 0 never produces a `fwd_spk` pulse.
- R10: After synchronous reset, all outputs are 0, the gate is off and both memories are empty.
- R11: Spike inputs present between strobes have no effect, and no output changes between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Time-step strobe, one cycle wide |
| pre_spk | input | 1 | Source spike for the current step |
| post_spk | input | 1 | Target spike for the current step |
| win_len | input | HIST_W | History window length, in steps |
| fwd_spk | output | 1 | Forwarded spike to the target |
| gate_on | output | 1 | Latched transmission gate state |
| ltp_evt | output | 1 | Potentiation detected in the last step |
| ltd_evt | output | 1 | Depression detected in the last step |

## Verification
The bench places target spikes exactly at the last step inside the window and at the first step outside it. An off-by-one counter would either learn too late or miss the final step. It then probes the step right after an event, when a memory that was not cleared would fire a spurious depression. Simultaneous source and target spikes are applied twice: first to load both memories with no prior history, then to trigger both detectors at once, so that a design favouring potentiation would leave the gate on. The bench also sends a source spike on the same strobe that turns the gate off. This confirms that a spike already in the relay still arrives, while later spikes are blocked. Noise spikes are applied between strobes to catch any state that advances on the clock rather than on the step.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  // Default width of the history down-counters.
  localparam int unsigned HIST_W_DEF = 4;
  // Default source-to-target delivery latency, in steps.
  localparam int unsigned FWD_LAT_DEF = 2;

  typedef struct packed {
    logic ltp;
    logic ltd;
  } evt_t;

  // Gate update: depression dominates potentiation.
  function automatic logic next_gate(input logic cur, input evt_t e);
    if (e.ltd)      return 1'b0;
    else if (e.ltp) return 1'b1;
    else            return cur;
  endfunction
endpackage

// File: rtl/stdp_hist_win.sv
module stdp_hist_win #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              spike,
  input  logic              clear,
  input  logic [HIST_W-1:0] win_len,
  output logic              valid
);
  localparam logic [HIST_W-1:0] ZERO = '0;
  localparam logic [HIST_W-1:0] ONE  = {{(HIST_W-1){1'b0}}, 1'b1};

  logic [HIST_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
    end else if (step) begin
      if (clear)               cnt_q <= ZERO;
      else if (spike)          cnt_q <= win_len;
      else if (cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
    end
  end

  assign valid = (cnt_q != ZERO);
endmodule

// File: rtl/stdp_gate_ctl.sv
module stdp_gate_ctl
  import stdp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  evt_t evt,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (rst)       gate <= 1'b0;
    else if (step) gate <= next_gate(gate, evt);
  end
endmodule

// File: rtl/stdp_relay.sv
module stdp_relay #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic din,
  output logic dout
);
  logic [LAT-1:0] stg_q;

  genvar gi;
  generate
    for (gi = 0; gi < LAT; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)       stg_q[0] <= 1'b0;
          else if (step) stg_q[0] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)       stg_q[gi] <= 1'b0;
          else if (step) stg_q[gi] <= stg_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[LAT-1];
endmodule

// File: rtl/stdp_synapse.sv
module stdp_synapse
  import stdp_pkg::*;
#(
  parameter int unsigned HIST_W  = HIST_W_DEF,
  parameter int unsigned FWD_LAT = FWD_LAT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              pre_spk,
  input  logic              post_spk,
  input  logic [HIST_W-1:0] win_len,
  output logic              fwd_spk,
  output logic              gate_on,
  output logic              ltp_evt,
  output logic              ltd_evt
);
  logic pre_hist_v;
  logic post_hist_v;
  evt_t evt_now;
  logic evt_any;
  logic relay_in;

  // Coincidence detection against the memories of earlier steps.
  always_comb begin
    evt_now.ltp = post_spk & pre_hist_v;
    evt_now.ltd = pre_spk  & post_hist_v;
  end
  assign evt_any  = evt_now.ltp | evt_now.ltd;
  assign relay_in = pre_spk & gate_on;

  stdp_hist_win #(.HIST_W(HIST_W)) u_pre_hist (
    .clk(clk), .rst(rst), .step(step), .spike(pre_spk),
    .clear(evt_any), .win_len(win_len), .valid(pre_hist_v)
  );

  stdp_hist_win #(.HIST_W(HIST_W)) u_post_hist (
    .clk(clk), .rst(rst), .step(step), .spike(post_spk),
    .clear(evt_any), .win_len(win_len), .valid(post_hist_v)
  );

  stdp_gate_ctl u_gate (
    .clk(clk), .rst(rst), .step(step), .evt(evt_now), .gate(gate_on)
  );

  stdp_relay #(.LAT(FWD_LAT)) u_relay (
    .clk(clk), .rst(rst), .step(step), .din(relay_in), .dout(fwd_spk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ltp_evt <= 1'b0;
      ltd_evt <= 1'b0;
    end else if (step) begin
      ltp_evt <= evt_now.ltp;
      ltd_evt <= evt_now.ltd;
    end
  end
endmodule

// File: rtl/stdp_synapse_chk.sv
module stdp_synapse_chk (
  input logic clk,
  input logic rst,
  input logic step,
  input logic fwd_spk,
  input logic gate_on,
  input logic ltp_evt,
  input logic ltd_evt,
  input logic pre_valid,
  input logic post_valid
);
  // R5: the gate rises only on a pure potentiation.
  a_r5_rise_on_ltp: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> (ltp_evt && !ltd_evt));

  // R5: a pure potentiation leaves the gate on.
  a_r5_ltp_sets_gate: assert property (@(posedge clk) disable iff (rst)
    (ltp_evt && !ltd_evt) |-> gate_on);

  // R6: the gate falls only on a depression.
  a_r6_fall_on_ltd: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_on) |-> ltd_evt);

  // R7: depression always leaves the gate off.
  a_r7_ltd_wins: assert property (@(posedge clk) disable iff (rst)
    ltd_evt |-> !gate_on);

  // R4: both memories are empty after any event.
  a_r4_hist_cleared: assert property (@(posedge clk) disable iff (rst)
    (ltp_evt || ltd_evt) |-> (!pre_valid && !post_valid));

  // R11: nothing visible moves without a strobe.
  a_r11_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(gate_on) && $stable(fwd_spk) &&
               $stable(ltp_evt) && $stable(ltd_evt)));
endmodule

bind stdp_synapse stdp_synapse_chk u_chk (
  .clk(clk), .rst(rst), .step(step), .fwd_spk(fwd_spk),
  .gate_on(gate_on), .ltp_evt(ltp_evt), .ltd_evt(ltd_evt),
  .pre_valid(pre_hist_v), .post_valid(post_hist_v)
);

// File: tb/tb_stdp_synapse.sv
module tb_stdp_synapse;
  localparam int  CLK_PERIOD = 10;
  localparam int  HW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_i = 1'b0;
  logic          pre_i = 1'b0;
  logic          post_i = 1'b0;
  logic [HW-1:0] win = 4'd3;
  logic          fwd_o, gate_o, ltp_o, ltd_o;

  int n_chk = 0;
  int n_fail = 0;

  // Scoreboard: packed {fwd, gate, ltp, ltd}.
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] last_exp = 4'b0000;

  // Reference state, built from the requirements.
  int   m_pre = 0;
  int   m_post = 0;
  logic m_gate = 1'b0;
  logic m_relay = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stdp_synapse #(.HIST_W(HW)) dut (
    .clk(clk), .rst(rst), .step(step_i), .pre_spk(pre_i),
    .post_spk(post_i), .win_len(win), .fwd_spk(fwd_o),
    .gate_on(gate_o), .ltp_evt(ltp_o), .ltd_evt(ltd_o)
  );

  function automatic logic [3:0] outs();
    return {fwd_o, gate_o, ltp_o, ltd_o};
  endfunction

  task automatic check(input string tag, input logic [3:0] act,
                       input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (fwd,gate,ltp,ltd)", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: applies one step, predicts its outcome, pushes it.
  task automatic do_step(input logic p, input logic q, input string tag);
    logic pv, qv, ltp, ltd, nfwd;
    @(negedge clk);
    pre_i = p; post_i = q; step_i = 1'b1;
    pv = (m_pre != 0);
    qv = (m_post != 0);
    ltp = q & pv;
    ltd = p & qv;
    nfwd = m_relay;
    m_relay = p & m_gate;
    if (ltd)      m_gate = 1'b0;
    else if (ltp) m_gate = 1'b1;
    if (ltp || ltd) begin
      m_pre = 0; m_post = 0;
    end else begin
      m_pre  = p ? int'(win) : ((m_pre  > 0) ? m_pre  - 1 : 0);
      m_post = q ? int'(win) : ((m_post > 0) ? m_post - 1 : 0);
    end
    last_exp = {nfwd, m_gate, ltp, ltd};
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    step_i = 1'b0; pre_i = 1'b1; post_i = 1'b1;   // noise between strobes
    @(negedge clk);
    check("R11 hold between steps", outs(), last_exp);
    pre_i = 1'b0; post_i = 1'b0;
  endtask

  // Monitor: compares each strobe's result half a cycle after it.
  initial begin
    forever begin
      @(posedge clk);
      if (step_i === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), outs(), exp_q.pop_front());
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", outs(), 4'b0000);

    // Learning inside the window; gate turns on and stays on.
    do_step(1'b1, 1'b0, "R1 pre loads memory");
    do_step(1'b0, 1'b0, "R1 idle");
    do_step(1'b0, 1'b1, "R2 potentiation");
    do_step(1'b0, 1'b0, "R5 gate persists");

    // Forwarding with the gate on.
    do_step(1'b1, 1'b0, "R8 pre enters relay");
    do_step(1'b0, 1'b0, "R8 fwd two steps later");
    do_step(1'b0, 1'b0, "R8 single pulse");
    for (int i = 0; i < 2; i++) do_step(1'b0, 1'b0, "R8 drain");

    // Depression turns the gate off; the in-flight spike still arrives.
    do_step(1'b0, 1'b1, "R3 post loads memory");
    do_step(1'b1, 1'b0, "R3 depression");
    do_step(1'b0, 1'b0, "R6 gate stays off");
    do_step(1'b0, 1'b0, "R6 gate stays off");

    // Gate off: source spikes are dropped.
    do_step(1'b1, 1'b0, "R9 pre while gate off");
    do_step(1'b0, 1'b0, "R9 no fwd");
    do_step(1'b0, 1'b0, "R9 no fwd");
    for (int i = 0; i < 2; i++) do_step(1'b0, 1'b0, "R9 drain");

    // Window edge: win_len+1 steps is too late.
    do_step(1'b1, 1'b0, "R1 pre");
    for (int i = 0; i < 3; i++) do_step(1'b0, 1'b0, "R1 wait");
    do_step(1'b0, 1'b1, "R1 post just outside window");
    for (int i = 0; i < 3; i++) do_step(1'b0, 1'b0, "R1 expire");

    // Last step inside the window.
    do_step(1'b1, 1'b0, "R1 pre");
    do_step(1'b0, 1'b0, "R1 wait");
    do_step(1'b0, 1'b0, "R1 wait");
    do_step(1'b0, 1'b1, "R1 post at last window step");

    // Event clears both memories: no depression follows.
    do_step(1'b1, 1'b0, "R4 post memory cleared");
    for (int i = 0; i < 4; i++) do_step(1'b0, 1'b0, "R4 drain");

    // Simultaneous events: depression wins.
    do_step(1'b1, 1'b1, "R7 both load no event");
    do_step(1'b1, 1'b1, "R7 depression wins");
    do_step(1'b0, 1'b0, "R7 gate off");
    for (int i = 0; i < 4; i++) do_step(1'b0, 1'b0, "R7 drain");

    // Zero-length window never learns; length one does.
    win = 4'd0;
    do_step(1'b1, 1'b0, "R1 zero window pre");
    do_step(1'b0, 1'b1, "R1 zero window no event");
    win = 4'd1;
    do_step(1'b1, 1'b0, "R1 unit window pre");
    do_step(1'b0, 1'b1, "R1 unit window potentiation");
    do_step(1'b0, 1'b0, "R5 gate on");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule